// File: doc/BRIEF.md
# Trigger-less Strip Hit Packet Encoder

This block turns every pulse seen on a resistive-plate chamber's pickup strips into its own hit packet. No trigger decision is involved. It watches two planes of strip discriminator outputs, X and Y, with 64 strips each by default. A free-running time counter stamps the moment a strip goes high. A per-strip counter measures how long the strip stays high. When the pulse ends, the finished record waits in that strip's own holding register.

A round-robin arbiter picks one waiting strip at a time. The chosen record is built into a 96-bit packet that carries these fields:

- the time stamp;
- the width;
- the strip's channel number;
- a chamber number taken from an input;
- an information field holding a running sequence number and a lost-hit flag.

The packet leaves as six 16-bit words on a valid/ready stream. Each strip has an enable bit, so noisy strips can be silenced; a silenced strip never reaches the output.

The strip and enable inputs are taken to be synchronous to the clock. One time-counter tick and one width unit each equal one clock cycle.

Top module: `hpk_encoder`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a strip pulse has completed. The time counter restarts from 0 and increases by one every cycle after reset.
- R2: The packet time stamp, bits [49:0], equals the counter value in the first cycle in which the strip input is sampled high.
- R3: The width field, bits [59:50], equals the number of cycles the strip input was sampled high. It saturates at 1023 for longer pulses and is never 0 in a valid packet.
- R4: The channel field, bits [67:60], encodes the strip as follows: bit 7 is 0, bit 6 is the plane (0 = X, 1 = Y), and bits [5:0] are the strip number. The chamber field, bits [83:68], carries `chamber_id`.
- R5: A packet is 96 bits with bits [95:94] zero. It is sent as six words, most significant word first. `out_last` is high on the sixth word only.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: A strip whose enable bit is low produces no packet. This covers pulses that start while it is disabled, pulses in progress when it is disabled, and completed hits still waiting when it is disabled.
- R8: When several strips hold completed hits, one is granted per packet slot. Strips are served in ascending index order (X strips 0..63, then Y strips as 64..127), starting just after the last strip granted and wrapping around.
- R9: If a strip completes a second pulse while its earlier hit is still waiting, the second pulse is dropped. Information bit 0 (bit 84) of the waiting packet is then set. Otherwise that bit is 0.
- R10: Information bits [9:2] (packet bits [93:86]) hold a sequence number. It starts at 0 after reset and increments by one for each packet. Information bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strip_x | input | N_STRIP | X-plane strip discriminator outputs |
| strip_y | input | N_STRIP | Y-plane strip discriminator outputs |
| en_x | input | N_STRIP | Per-strip enable, X plane |
| en_y | input | N_STRIP | Per-strip enable, Y plane |
| chamber_id | input | 16 | Chamber number placed in every packet |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | A packet word is presented |
| out_data | output | 16 | Packet word |
| out_last | output | 1 | Final word of a packet |

## Verification
The assertions assume that the strip and enable inputs change only away from the clock edge and are already synchronous, single-bit-per-cycle levels. They also assume that `out_ready` may drop at any cycle, including mid-packet.

The bench drives strips and enables on the falling edge and changes ready shortly after the rising edge. Every pulse is therefore seen as a clean level for a whole number of cycles.

Several situations are built on purpose:

- **Lost hits and waiting-then-masked hits:** the serializer is first stalled with another packet, so a strip's hit must actually wait in its holding register.
- **Arbitration order:** simultaneous completions are produced by ending several pulses in the same cycle.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
    localparam int TS_W    = 50;
    localparam int WID_W   = 10;
    localparam int CH_W    = 8;
    localparam int CHAM_W  = 16;
    localparam int INFO_W  = 10;
    localparam int SEQ_W   = INFO_W - 2;
    localparam int PKT_W   = 96;
    localparam int WORD_W  = 16;
    localparam int N_WORDS = PKT_W / WORD_W;
    localparam int PAD_W   = PKT_W - (TS_W + WID_W + CH_W + CHAM_W + INFO_W);

    // one completed hit waiting for its turn
    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [WID_W-1:0] width;
        logic             lost;
    } hit_rec_t;

    // layout, LSB upward: time, width, channel, chamber, info, pad
    function automatic logic [PKT_W-1:0] pack_hit(
        input hit_rec_t          rec,
        input logic [CH_W-1:0]   ch,
        input logic [CHAM_W-1:0] cham,
        input logic [SEQ_W-1:0]  seq
    );
        logic [INFO_W-1:0] info;
        info = {seq, 1'b0, rec.lost};
        return {{PAD_W{1'b0}}, info, cham, ch, rec.width, rec.ts};
    endfunction
endpackage

// File: rtl/hpk_chan.sv
module hpk_chan
    import hpk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            strip_in,
    input  logic            enable,
    input  logic            grant,
    input  logic [TS_W-1:0] ts_now,
    output logic            req,
    output hit_rec_t        rec
);
    localparam logic [WID_W-1:0] CNT_MAX = {WID_W{1'b1}};

    typedef struct packed {
        logic             prev;
        logic             active;
        logic             pend;
        logic [WID_W-1:0] cnt;
        logic [TS_W-1:0]  ts_cap;
        hit_rec_t         held;
    } chan_st_t;

    chan_st_t q, d;
    logic rise, fall;

    always_comb begin
        d      = q;
        d.prev = strip_in;
        rise   = strip_in & ~q.prev & enable;
        fall   = ~strip_in & q.active;
        if (!enable) begin
            d.active    = 1'b0;
            d.pend      = 1'b0;
            d.held.lost = 1'b0;
        end else begin
            if (rise) begin
                d.active = 1'b1;
                d.cnt    = WID_W'(1);
                d.ts_cap = ts_now;
            end else if (q.active && strip_in && q.cnt != CNT_MAX) begin
                d.cnt = q.cnt + WID_W'(1);
            end
            if (fall) begin
                d.active = 1'b0;
                if (q.pend && !grant) begin
                    d.held.lost = 1'b1;
                end else begin
                    d.pend       = 1'b1;
                    d.held.ts    = q.ts_cap;
                    d.held.width = q.cnt;
                    d.held.lost  = 1'b0;
                end
            end else if (grant) begin
                d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign req = q.pend & enable;
    assign rec = q.held;

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !req);
    p_width_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        req |-> rec.width != '0);
    p_grant_pending_r8: assert property (@(posedge clk) disable iff (rst)
        grant |-> req);
endmodule

// File: rtl/hpk_rr_arb.sv
module hpk_rr_arb #(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_st_t;

    arb_st_t q, d;
    logic found;

    always_comb begin
        d       = q;
        found   = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(q.ptr) + i) % N;
            if (!found && req[j]) begin
                found   = 1'b1;
                gnt_idx = IDX_W'(j);
            end
        end
        gnt_any = found & advance;
        gnt     = '0;
        if (gnt_any) begin
            gnt[gnt_idx] = 1'b1;
            d.ptr = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    p_grant_subset_r8: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    p_grant_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
endmodule

// File: rtl/hpk_pkt_ser.sv
module hpk_pkt_ser
    import hpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PKT_W-1:0]  pkt_in,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    localparam int WI_W = $clog2(N_WORDS);

    typedef struct packed {
        logic             busy;
        logic [WI_W-1:0]  idx;
        logic [PKT_W-1:0] sh;
    } ser_st_t;

    ser_st_t q, d;

    assign out_valid = q.busy;
    assign out_data  = q.sh[PKT_W-1 -: WORD_W];
    assign out_last  = q.busy && (int'(q.idx) == N_WORDS - 1);
    assign can_load  = !q.busy || (out_ready && out_last);

    always_comb begin
        d = q;
        if (load) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.sh   = pkt_in;
        end else if (q.busy && out_ready) begin
            if (out_last) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + WI_W'(1);
                d.sh  = q.sh << WORD_W;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
    p_load_free_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> can_load);
endmodule

// File: rtl/hpk_encoder.sv
module hpk_encoder
    import hpk_pkg::*;
#(
    parameter int N_STRIP = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_STRIP-1:0] strip_x,
    input  logic [N_STRIP-1:0] strip_y,
    input  logic [N_STRIP-1:0] en_x,
    input  logic [N_STRIP-1:0] en_y,
    input  logic [CHAM_W-1:0]  chamber_id,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_last
);
    localparam int NCH   = 2 * N_STRIP;
    localparam int IDX_W = $clog2(NCH);

    typedef struct packed {
        logic [TS_W-1:0]  tstamp;
        logic [SEQ_W-1:0] seq;
    } top_st_t;

    top_st_t q, d;

    logic [NCH-1:0]   strips, ens, ch_req, ch_gnt;
    hit_rec_t         ch_rec [NCH];
    logic [IDX_W-1:0] gnt_idx;
    logic             gnt_any, can_load;
    logic [PKT_W-1:0] pkt;

    assign strips = {strip_y, strip_x};
    assign ens    = {en_y, en_x};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hpk_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .strip_in (strips[c]),
            .enable   (ens[c]),
            .grant    (ch_gnt[c]),
            .ts_now   (q.tstamp),
            .req      (ch_req[c]),
            .rec      (ch_rec[c])
        );
    end

    hpk_rr_arb #(.N(NCH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (ch_req),
        .advance (can_load),
        .gnt     (ch_gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign pkt = pack_hit(ch_rec[gnt_idx], CH_W'(gnt_idx), chamber_id, q.seq);

    hpk_pkt_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (gnt_any),
        .pkt_in    (pkt),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always_comb begin
        d        = q;
        d.tstamp = q.tstamp + TS_W'(1);
        if (gnt_any) d.seq = q.seq + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: tb/tb_hpk_encoder.sv
`timescale 1ns/1ps
module tb_hpk_encoder;
    localparam int NS  = 64;
    localparam int NCH = 2 * NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NCH-1:0] strips = '0;
    logic [NCH-1:0] ens    = '1;
    logic [15:0]    cham   = 16'hA5C3;
    logic           rdy    = 1'b1;
    logic           ov, ol;
    logic [15:0]    od;

    hpk_encoder #(.N_STRIP(NS)) dut (
        .clk(clk), .rst(rst),
        .strip_x(strips[NS-1:0]), .strip_y(strips[NCH-1:NS]),
        .en_x(ens[NS-1:0]), .en_y(ens[NCH-1:NS]),
        .chamber_id(cham), .out_ready(rdy),
        .out_valid(ov), .out_data(od), .out_last(ol)
    );

    longint cyc = 0;
    int n_chk = 0, n_bad = 0, pop_cnt = 0, last_ch = NCH - 1;
    logic [95:0] rx_q[$];
    logic [95:0] asm_pkt = '0;
    int  wcnt = 0;
    bit  hold_prev = 0;
    logic [15:0] data_prev;
    logic last_prev;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // word collector, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_prev)
                check(ov && od == data_prev && ol == last_prev, "R6", "hold under stall",
                      longint'({ov, ol, od}), longint'({1'b1, last_prev, data_prev}));
            hold_prev = ov && !rdy;
            data_prev = od;
            last_prev = ol;
            if (ov && rdy) begin
                asm_pkt = {asm_pkt[79:0], od};
                wcnt++;
                if (wcnt == 6) begin
                    check(ol == 1'b1, "R5", "last on word six", longint'(ol), 1);
                    rx_q.push_back(asm_pkt);
                    wcnt = 0;
                end else begin
                    check(ol == 1'b0, "R5", "last early", longint'(ol), 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        summary();
    end

    task automatic pulse_set(input logic [NCH-1:0] m, input int h, output longint ts);
        @(negedge clk);
        strips = strips | m;
        ts = cyc;
        repeat (h) @(negedge clk);
        strips = strips & ~m;
    endtask

    task automatic pulse(input int ch, input int h, output longint ts);
        logic [NCH-1:0] m;
        m = '0;
        m[ch] = 1'b1;
        pulse_set(m, h, ts);
    endtask

    task automatic set_ready(input bit v);
        @(posedge clk);
        #1 rdy = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pkt(input string tag, input int ch, input longint ts,
                              input int h, input bit lost);
        int t;
        logic [95:0] p;
        int w;
        t = 0;
        while (rx_q.size() == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (rx_q.size() == 0) begin
            check(0, tag, "packet timeout", 0, 1);
            return;
        end
        p = rx_q.pop_front();
        w = (h > 1023) ? 1023 : h;
        check(int'(p[67:60]) == ch, tag, "channel", longint'(p[67:60]), ch);
        check(longint'(p[49:0]) == ts, "R2", "time stamp", longint'(p[49:0]), ts);
        check(int'(p[59:50]) == w, "R3", "width", longint'(p[59:50]), w);
        check(p[84] == lost, "R9", "lost flag", longint'(p[84]), longint'(lost));
        check(p[83:68] == cham, "R4", "chamber", longint'(p[83:68]), longint'(cham));
        check(int'(p[93:86]) == pop_cnt % 256, "R10", "sequence",
              longint'(p[93:86]), pop_cnt % 256);
        check(p[95:94] == 2'b00 && p[85] == 1'b0, "R5", "pad and info1",
              longint'({p[95:94], p[85]}), 0);
        pop_cnt++;
        last_ch = int'(p[67:60]);
    endtask

    task automatic t_reset();
        check(ov == 1'b0, "R1", "valid after reset", longint'(ov), 0);
        idle(10);
        check(ov == 1'b0 && rx_q.size() == 0, "R1", "quiet with no pulse",
              longint'(ov), 0);
    endtask

    task automatic t_single();
        longint ts;
        pulse(5, 7, ts);
        expect_pkt("R4", 5, ts, 7, 0);
        pulse(127, 3, ts);
        expect_pkt("R4", 127, ts, 3, 0);
        pulse(64, 1, ts);
        expect_pkt("R4", 64, ts, 1, 0);
        cham = 16'h1234;
        pulse(63, 2, ts);
        expect_pkt("R4", 63, ts, 2, 0);
    endtask

    task automatic t_saturate();
        longint ts;
        pulse(12, 1100, ts);
        expect_pkt("R3", 12, ts, 1100, 0);
        pulse(13, 1023, ts);
        expect_pkt("R3", 13, ts, 1023, 0);
    endtask

    task automatic t_backpressure();
        longint ts;
        set_ready(0);
        pulse(5, 4, ts);
        idle(20);
        check(ov == 1'b1, "R6", "valid held while stalled", longint'(ov), 1);
        check(rx_q.size() == 0, "R6", "nothing taken while stalled",
              longint'(rx_q.size()), 0);
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            #1 rdy = (i % 3 != 0);
        end
        set_ready(1);
        expect_pkt("R6", 5, ts, 4, 0);
    endtask

    task automatic t_rr(input logic [NCH-1:0] m);
        longint ts;
        int p;
        pulse_set(m, 5, ts);
        p = (last_ch + 1) % NCH;
        for (int k = 0; k < NCH; k++) begin
            int c;
            c = (p + k) % NCH;
            if (m[c]) expect_pkt("R8", c, ts, 5, 0);
        end
    endtask

    task automatic t_mask();
        longint ts, ts2;
        ens[20] = 1'b0;
        pulse(20, 5, ts);
        idle(40);
        check(rx_q.size() == 0 && !ov, "R7", "disabled strip silent",
              longint'(rx_q.size()), 0);
        ens[20] = 1'b1;
        @(negedge clk);
        strips[21] = 1'b1;
        idle(3);
        ens[21] = 1'b0;
        idle(3);
        ens[21] = 1'b1;
        idle(4);
        strips[21] = 1'b0;
        idle(40);
        check(rx_q.size() == 0 && !ov, "R7", "pulse cut by disable",
              longint'(rx_q.size()), 0);
        pulse(21, 2, ts);
        expect_pkt("R7", 21, ts, 2, 0);
        set_ready(0);
        pulse(41, 2, ts);
        pulse(22, 2, ts2);
        idle(3);
        ens[22] = 1'b0;
        idle(2);
        ens[22] = 1'b1;
        set_ready(1);
        expect_pkt("R7", 41, ts, 2, 0);
        idle(40);
        check(rx_q.size() == 0 && !ov, "R7", "waiting hit dropped on disable",
              longint'(rx_q.size()), 0);
    endtask

    task automatic t_lost();
        longint ta, tb, tc;
        set_ready(0);
        pulse(40, 3, ta);
        idle(3);
        pulse(30, 4, tb);
        idle(3);
        pulse(30, 2, tc);
        idle(5);
        set_ready(1);
        expect_pkt("R9", 40, ta, 3, 0);
        expect_pkt("R9", 30, tb, 4, 1);
        idle(10);
        check(rx_q.size() == 0, "R9", "dropped pulse not sent",
              longint'(rx_q.size()), 0);
        pulse(30, 3, tc);
        expect_pkt("R9", 30, tc, 3, 0);
    endtask

    initial begin
        logic [NCH-1:0] m;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_saturate();
        t_backpressure();
        m = '0; m[3] = 1; m[10] = 1; m[70] = 1; m[127] = 1;
        t_rr(m);
        m = '0; m[3] = 1; m[4] = 1; m[127] = 1; m[0] = 1;
        t_rr(m);
        t_mask();
        t_lost();
        idle(10);
        summary();
    end
endmodule